// File: doc/BRIEF.md
# Remote DMA Data Port with Ring Wrap

This block is the host-side data window into a network controller's packet buffer. Software programs a remote pointer, a byte count, and a ring given as a start page and a stop page. It then moves data through one data port. Each accepted data port access reads or writes consecutive buffer bytes starting at the remote pointer. After the access, the pointer advances by the bytes moved. When the advanced pointer lands exactly on the stop page, it jumps back to the start page. The remaining count shrinks by the bytes moved and stops at zero. When the count runs out, a completion bit is set in the interrupt status register, and the interrupt line follows the status and mask registers.

The buffer RAM is byte-wide and synchronous, with one cycle of read latency. A sequencer therefore serves each access as a run of byte cycles. The sequencer has three states:

- **IDLE** waits for a request. It moves to XFER (transition *accept*), or it stays in IDLE when a write arrives with a zero count (transition *reject*).
- **XFER** issues one RAM byte per cycle. It moves to COMMIT after the last byte (transition *last byte*).
- **COMMIT** applies the pointer, count and status update. It always returns to IDLE (transition *retire*).

Multi-byte data uses little-endian lanes.

Top module: `rdma_ring_port`

## Requirements
- R1: When bit 0 of the configuration register (offset 4) is 1, a narrow-path access (dp_wide=0) moves 2 bytes taken from dp_wdata[15:0]. When that bit is 0, it moves 1 byte from dp_wdata[7:0].
- R2: A wide-path access (dp_wide=1) moves 4 bytes whatever the configuration bit holds.
- R3: Byte i of an access goes to or comes from buffer address pointer+i. Data bits [8i+7:8i] carry that byte, and unused upper bits of read data are zero.
- R4: After an accepted access, the pointer (offset 0) has grown by the number of bytes moved, modulo 2^16.
- R5: If the grown pointer equals the stop page (offset 3) times 256, the pointer is reloaded with the start page (offset 2) times 256. Any other value, including one that passes the stop address, is kept unchanged.
- R6: If the count (offset 1) exceeds the bytes moved, it is reduced by that amount and the status register is left as it was.
- R7: If the count is less than or equal to the bytes moved, the count becomes 0 and status bit 6 (offset 6) is set.
- R8: A write request made while the count is 0 is dropped. There is no RAM write, no pointer or count change, and dp_busy stays low.
- R9: A read request made while the count is 0 is still carried out. The pointer advances, the count stays 0, and status bit 6 is set again.
- R10: irq is high exactly when some status bit and the matching bit of the mask register (offset 5) are both 1. Writing 1 to a status bit clears that bit.
- R11: An accepted access of N bytes keeps dp_busy high for N+1 cycles after the accepting clock edge. For a read, dp_rvalid is high for the single cycle after that, carrying the assembled data.
- R12: When a completion and a status clear of bit 6 hit the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| dp_req | input | 1 | Data port request, sampled while idle |
| dp_we | input | 1 | 1 = write, 0 = read |
| dp_wide | input | 1 | Selects the 4-byte path |
| dp_wdata | input | 32 | Data port write data |
| dp_busy | output | 1 | Access in progress |
| dp_rvalid | output | 1 | Read data valid, one cycle |
| dp_rdata | output | 32 | Read data |
| ram_addr | output | 16 | Buffer RAM byte address |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_re | output | 1 | Buffer RAM read enable |
| ram_wdata | output | 8 | Buffer RAM write byte |
| ram_rdata | input | 8 | Buffer RAM read byte, one cycle after ram_re |
| irq | output | 1 | Interrupt request |

## Verification
A completion can be raised in the COMMIT cycle while software's write-one-to-clear of the same status bit lands on the same clock edge. The bench starts a two-byte read with a count of 2. It then times a status register write so that the write strobe is high during the COMMIT cycle. The bench judges the result by reading status bit 6 back as set and by seeing irq high with the mask enabled. A scoreboard also confirms that the read data from that same access arrives intact.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    // Register offsets on the programming port
    localparam logic [2:0] RA_PTR   = 3'd0;
    localparam logic [2:0] RA_CNT   = 3'd1;
    localparam logic [2:0] RA_START = 3'd2;
    localparam logic [2:0] RA_STOP  = 3'd3;
    localparam logic [2:0] RA_CFG   = 3'd4;
    localparam logic [2:0] RA_MASK  = 3'd5;
    localparam logic [2:0] RA_STAT  = 3'd6;

    localparam int unsigned STAT_WIDTH = 8;
    localparam int unsigned DONE_POS   = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/rdma_advance.sv
module rdma_advance #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PAGE_W = 8,
    parameter int unsigned STEP_W = 3,
    localparam int unsigned OFFS_W = ADDR_W - PAGE_W
) (
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [STEP_W-1:0] step,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic [ADDR_W-1:0] nxt_ptr,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              exhausted
);

    logic [ADDR_W-1:0] bumped;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] stop_addr;

    always_comb begin
        start_addr = {start_pg, {OFFS_W{1'b0}}};
        stop_addr  = {stop_pg, {OFFS_W{1'b0}}};
        bumped     = cur_ptr + ADDR_W'(step);
        nxt_ptr    = (bumped == stop_addr) ? start_addr : bumped;
        exhausted  = (cur_cnt <= CNT_W'(step));
        nxt_cnt    = exhausted ? '0 : (cur_cnt - CNT_W'(step));
    end

endmodule

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned PAGE_W   = 8,
    parameter int unsigned STEP_W   = 3,
    parameter int unsigned STAT_W   = STAT_WIDTH,
    parameter int unsigned DONE_BIT = DONE_POS,
    localparam int unsigned REG_W   = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
    localparam int unsigned OFFS_W  = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_ptr,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic [STEP_W-1:0] upd_step,
    input  logic              set_done,
    output logic [ADDR_W-1:0] ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic [PAGE_W-1:0] start_pg,
    output logic [PAGE_W-1:0] stop_pg,
    output logic              cfg16,
    output logic              irq
);

    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] isr;
    logic [STAT_W-1:0] isr_nxt;

    // Clear first, then set: a completion wins over a same-edge clear
    always_comb begin
        isr_nxt = isr;
        if (reg_we && reg_addr == RA_STAT) begin
            isr_nxt = isr & ~reg_wdata[STAT_W-1:0];
        end
        if (set_done) begin
            isr_nxt[DONE_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            cnt      <= '0;
            start_pg <= '0;
            stop_pg  <= '0;
            cfg16    <= 1'b0;
            mask     <= '0;
            isr      <= '0;
        end else begin
            isr <= isr_nxt;
            if (reg_we) begin
                unique case (reg_addr)
                    RA_PTR:   ptr      <= reg_wdata[ADDR_W-1:0];
                    RA_CNT:   cnt      <= reg_wdata[CNT_W-1:0];
                    RA_START: start_pg <= reg_wdata[PAGE_W-1:0];
                    RA_STOP:  stop_pg  <= reg_wdata[PAGE_W-1:0];
                    RA_CFG:   cfg16    <= reg_wdata[0];
                    RA_MASK:  mask     <= reg_wdata[STAT_W-1:0];
                    default:  ;
                endcase
            end
            // The transfer update takes priority over a register write
            if (upd_en) begin
                ptr <= upd_ptr;
                cnt <= upd_cnt;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_PTR:   reg_rdata = REG_W'(ptr);
            RA_CNT:   reg_rdata = REG_W'(cnt);
            RA_START: reg_rdata = REG_W'(start_pg);
            RA_STOP:  reg_rdata = REG_W'(stop_pg);
            RA_CFG:   reg_rdata = REG_W'(cfg16);
            RA_MASK:  reg_rdata = REG_W'(mask);
            RA_STAT:  reg_rdata = REG_W'(isr);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(isr & mask);

    // R6: count shrinks by the step when more bytes than the step remain
    p_cnt_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && cnt > CNT_W'(upd_step))
        |=> (cnt == $past(cnt) - CNT_W'($past(upd_step))));

    // R6: a non-exhausting update leaves status untouched
    p_status_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !set_done && !reg_we) |=> (isr == $past(isr)));

    // R7 and R12: completion always lands in status bit
    p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> isr[DONE_BIT]);

    // R5: after an update the pointer never rests on the stop address
    p_stop_avoided_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !reg_we && start_pg != stop_pg)
        |=> (ptr != {stop_pg, {OFFS_W{1'b0}}}));

endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NBYTES = DATA_W / 8,
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int unsigned STEP_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_req,
    input  logic              dp_we,
    input  logic              dp_wide,
    input  logic [DATA_W-1:0] dp_wdata,
    output logic              dp_busy,
    output logic              dp_rvalid,
    output logic [DATA_W-1:0] dp_rdata,
    input  logic              cfg16,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              cnt_zero,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              upd_en,
    output logic [STEP_W-1:0] step
);

    seq_state_t        state;
    seq_state_t        state_nxt;
    logic              op_we;
    logic [STEP_W-1:0] op_step;
    logic [DATA_W-1:0] op_data;
    logic [IDX_W-1:0]  idx;
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic              rvalid_q;
    logic [STEP_W-1:0] req_step;
    logic              accept;
    logic              last_byte;

    always_comb begin
        if (dp_wide) begin
            req_step = STEP_W'(NBYTES);
        end else if (cfg16) begin
            req_step = STEP_W'(2);
        end else begin
            req_step = STEP_W'(1);
        end
        accept    = dp_req && !(dp_we && cnt_zero);
        last_byte = ({1'b0, idx} == (op_step - STEP_W'(1)));
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nxt = ST_XFER;
            ST_XFER:   if (last_byte) state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Operation datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_we    <= 1'b0;
            op_step  <= STEP_W'(1);
            op_data  <= '0;
            idx      <= '0;
            cap_en   <= 1'b0;
            cap_idx  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            cap_en   <= ram_re;
            cap_idx  <= idx;
            rvalid_q <= (state == ST_COMMIT) && !op_we;
            if (cap_en) begin
                op_data[{cap_idx, 3'b000} +: 8] <= ram_rdata;
            end
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_we   <= dp_we;
                        op_step <= req_step;
                        op_data <= dp_we ? dp_wdata : '0;
                        idx     <= '0;
                    end
                end
                ST_XFER:   idx <= idx + IDX_W'(1);
                ST_COMMIT: idx <= '0;
                default:   ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ram_addr  = ptr + ADDR_W'(idx);
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_wdata = op_data[{idx, 3'b000} +: 8];
        upd_en    = 1'b0;
        dp_busy   = 1'b1;
        unique case (state)
            ST_IDLE:   dp_busy = 1'b0;
            ST_XFER: begin
                ram_we = op_we;
                ram_re = !op_we;
            end
            ST_COMMIT: upd_en = 1'b1;
            default:   dp_busy = 1'b0;
        endcase
        step      = op_step;
        dp_rvalid = rvalid_q;
        dp_rdata  = op_data;
    end

    // R8: a write with no bytes left leaves the port idle
    p_zero_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && dp_req && dp_we && cnt_zero) |=> !dp_busy);

    // R11: read data is presented only right after a read commit
    p_rvalid_after_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rvalid |-> ($past(state) == ST_COMMIT && !$past(op_we)));

    // R1 and R2: a running access always has a legal byte count
    p_step_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dp_busy |-> (op_step == STEP_W'(1) || op_step == STEP_W'(2)
                     || op_step == STEP_W'(NBYTES)));

endmodule

// File: rtl/rdma_ring_port.sv
module rdma_ring_port
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PAGE_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned REG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
    localparam int unsigned NBYTES = DATA_W / 8,
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int unsigned STEP_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dp_req,
    input  logic              dp_we,
    input  logic              dp_wide,
    input  logic [DATA_W-1:0] dp_wdata,
    output logic              dp_busy,
    output logic              dp_rvalid,
    output logic [DATA_W-1:0] dp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              irq
);

    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  cnt;
    logic [PAGE_W-1:0] start_pg;
    logic [PAGE_W-1:0] stop_pg;
    logic              cfg16;
    logic              upd_en;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] nxt_ptr;
    logic [CNT_W-1:0]  nxt_cnt;
    logic              exhausted;
    logic              set_done;

    assign set_done = upd_en && exhausted;

    rdma_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dp_req    (dp_req),
        .dp_we     (dp_we),
        .dp_wide   (dp_wide),
        .dp_wdata  (dp_wdata),
        .dp_busy   (dp_busy),
        .dp_rvalid (dp_rvalid),
        .dp_rdata  (dp_rdata),
        .cfg16     (cfg16),
        .ptr       (ptr),
        .cnt_zero  (cnt == '0),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .upd_en    (upd_en),
        .step      (step)
    );

    rdma_advance #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .PAGE_W(PAGE_W),
        .STEP_W(STEP_W)
    ) u_adv (
        .cur_ptr  (ptr),
        .cur_cnt  (cnt),
        .step     (step),
        .start_pg (start_pg),
        .stop_pg  (stop_pg),
        .nxt_ptr  (nxt_ptr),
        .nxt_cnt  (nxt_cnt),
        .exhausted(exhausted)
    );

    rdma_regs #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .PAGE_W(PAGE_W),
        .STEP_W(STEP_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .upd_en   (upd_en),
        .upd_ptr  (nxt_ptr),
        .upd_cnt  (nxt_cnt),
        .upd_step (step),
        .set_done (set_done),
        .ptr      (ptr),
        .cnt      (cnt),
        .start_pg (start_pg),
        .stop_pg  (stop_pg),
        .cfg16    (cfg16),
        .irq      (irq)
    );

endmodule

// File: tb/test_rdma_ring_port.sv
module test_rdma_ring_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dp_req = 1'b0;
    logic        dp_we = 1'b0;
    logic        dp_wide = 1'b0;
    logic [31:0] dp_wdata = '0;
    logic        dp_busy;
    logic        dp_rvalid;
    logic [31:0] dp_rdata;
    logic [15:0] ram_addr;
    logic        ram_we;
    logic        ram_re;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic        irq;

    always #5 clk = ~clk;

    rdma_ring_port i_rdma_ring_port (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dp_req(dp_req), .dp_we(dp_we), .dp_wide(dp_wide), .dp_wdata(dp_wdata),
        .dp_busy(dp_busy), .dp_rvalid(dp_rvalid), .dp_rdata(dp_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .irq(irq)
    );

    // Buffer RAM: byte-wide, one-cycle read latency
    logic [7:0] mem [0:4095];
    int         ram_writes = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 7 + 3);
        end else begin
            if (ram_we) begin
                mem[ram_addr[11:0]] <= ram_wdata;
                ram_writes <= ram_writes + 1;
            end
            if (ram_re) ram_rdata <= mem[ram_addr[11:0]];
        end
    end

    // Reference model state
    logic [7:0]  model [0:4095];
    logic [15:0] m_ptr = 0, m_cnt = 0;
    logic [7:0]  m_start = 0, m_stop = 0, m_mask = 0, m_isr = 0;
    logic        m_cfg = 0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [31:0] exp_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as the design presents it
    always @(negedge clk) begin
        if (rst_n && dp_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check("R3 read data", dp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            3'd0: m_ptr = d;
            3'd1: m_cnt = d;
            3'd2: m_start = d[7:0];
            3'd3: m_stop = d[7:0];
            3'd4: m_cfg = d[0];
            3'd5: m_mask = d[7:0];
            3'd6: m_isr = m_isr & ~d[7:0];
            default: ;
        endcase
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Applies an access to the model; returns byte count and acceptance
    task automatic model_access(input logic we, input logic wide, input logic [31:0] d,
                                output int n, output bit acc);
        logic [31:0] rd;
        logic [15:0] bumped;
        n = wide ? 4 : (m_cfg ? 2 : 1);
        acc = !(we && m_cnt == 0);
        if (!acc) return;
        rd = '0;
        for (int i = 0; i < n; i++) begin
            if (we) model[12'(m_ptr + 16'(i))] = d[8*i +: 8];
            else    rd[8*i +: 8] = model[12'(m_ptr + 16'(i))];
        end
        if (!we) exp_q.push_back(rd);
        bumped = m_ptr + 16'(n);
        m_ptr = (bumped == {m_stop, 8'h00}) ? {m_start, 8'h00} : bumped;
        if (m_cnt <= 16'(n)) begin
            m_cnt = 0;
            m_isr[6] = 1'b1;
        end else begin
            m_cnt = m_cnt - 16'(n);
        end
    endtask

    task automatic dp_start(input logic we, input logic wide, input logic [31:0] d,
                            output int n, output bit acc);
        model_access(we, wide, d, n, acc);
        @(negedge clk);
        dp_req = 1'b1; dp_we = we; dp_wide = wide; dp_wdata = d;
        @(negedge clk);
        dp_req = 1'b0;
    endtask

    task automatic dp_access(input string tag, input logic we, input logic wide,
                             input logic [31:0] d);
        int n;
        bit acc;
        int cyc;
        dp_start(we, wide, d, n, acc);
        cyc = 1;
        while (dp_busy) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, " R11 busy length"}, 32'(cyc), acc ? 32'(n + 2) : 32'd1);
    endtask

    task automatic verify(input string tag);
        logic [15:0] v;
        reg_rd(3'd0, v); check({tag, " R4 pointer"}, 32'(v), 32'(m_ptr));
        reg_rd(3'd1, v); check({tag, " R6 count"}, 32'(v), 32'(m_cnt));
        reg_rd(3'd6, v); check({tag, " R7 status"}, 32'(v), 32'(m_isr));
        check({tag, " R10 irq"}, 32'(irq), 32'(|(m_isr & m_mask)));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            check("watchdog", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int wbase;
        int n;
        bit acc;
        for (int i = 0; i < 4096; i++) model[i] = 8'(i * 7 + 3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        for (int a = 0; a < 7; a++) begin
            reg_rd(3'(a), v);
            check("reset register", 32'(v), 32'd0);
        end
        check("reset irq", 32'(irq), 32'd0);
        check("reset busy", 32'(dp_busy), 32'd0);

        // Ring pages 1..3, byte-mode writes (R1)
        reg_wr(3'd2, 16'h0001);
        reg_wr(3'd3, 16'h0003);
        reg_wr(3'd0, 16'h0100);
        reg_wr(3'd1, 16'd10);
        reg_wr(3'd4, 16'd0);
        dp_access("R1 byte write", 1'b1, 1'b0, 32'hFFFF_FFA1);
        dp_access("R1 byte write", 1'b1, 1'b0, 32'h0000_00B2);
        dp_access("R1 byte write", 1'b1, 1'b0, 32'h0000_00C3);
        verify("R1 byte");
        reg_wr(3'd4, 16'd1);
        dp_access("R1 half write", 1'b1, 1'b0, 32'h1234_BEEF);
        verify("R1 half");
        dp_access("R2 wide write", 1'b1, 1'b1, 32'h4433_2211);
        verify("R2 wide");
        check("R3 lane 0 stored", 32'(mem[12'h105]), 32'h11);
        check("R3 lane 3 stored", 32'(mem[12'h108]), 32'h44);
        reg_wr(3'd4, 16'd0);
        dp_access("R7 last byte", 1'b1, 1'b0, 32'h0000_005A);
        verify("R7 exhaust");

        // Write with zero count is dropped
        wbase = ram_writes;
        dp_access("R8 zero write", 1'b1, 1'b0, 32'h0000_0077);
        check("R8 no RAM write", 32'(ram_writes), 32'(wbase));
        verify("R8 zero");

        // Read back with each width (R3)
        reg_wr(3'd0, 16'h0100);
        reg_wr(3'd1, 16'd20);
        dp_access("R3 byte read", 1'b0, 1'b0, 32'h0);
        dp_access("R3 byte read", 1'b0, 1'b0, 32'h0);
        dp_access("R3 byte read", 1'b0, 1'b0, 32'h0);
        reg_wr(3'd4, 16'd1);
        dp_access("R3 half read", 1'b0, 1'b0, 32'h0);
        dp_access("R3 wide read", 1'b0, 1'b1, 32'h0);
        verify("R6 reads");

        // Ring wrap (R5)
        reg_wr(3'd6, 16'h0040);
        reg_wr(3'd0, 16'h02FC);
        reg_wr(3'd1, 16'd100);
        dp_access("R5 wide wrap", 1'b1, 1'b1, 32'hDDCC_BBAA);
        verify("R5 wide wrap");
        reg_wr(3'd4, 16'd0);
        reg_wr(3'd0, 16'h02FF);
        dp_access("R5 byte wrap", 1'b1, 1'b0, 32'h0000_0099);
        verify("R5 byte wrap");
        reg_wr(3'd0, 16'h02FE);
        dp_access("R5 overshoot", 1'b1, 1'b1, 32'h0102_0304);
        verify("R5 overshoot");

        // Count saturation (R7)
        reg_wr(3'd0, 16'h0200);
        reg_wr(3'd1, 16'd3);
        dp_access("R7 saturate", 1'b0, 1'b1, 32'h0);
        verify("R7 saturate");

        // Interrupt mask and clear (R10)
        reg_wr(3'd5, 16'h0040);
        check("R10 irq on", 32'(irq), 32'd1);
        reg_wr(3'd6, 16'h0040);
        verify("R10 cleared");

        // Read at zero count (R9)
        dp_access("R9 zero read", 1'b0, 1'b0, 32'h0);
        verify("R9 zero read");
        reg_wr(3'd5, 16'h0001);
        check("R10 other mask", 32'(irq), 32'd0);

        // Completion and clear on the same edge (R12)
        reg_wr(3'd5, 16'h0040);
        reg_wr(3'd6, 16'h0040);
        reg_wr(3'd1, 16'd2);
        reg_wr(3'd4, 16'd1);
        dp_start(1'b0, 1'b0, 32'h0, n, acc);
        @(negedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 16'h0040;
        @(negedge clk);
        reg_we = 1'b0;
        while (dp_busy) @(negedge clk);
        @(negedge clk);
        verify("R12 set wins");

        repeat (3) @(negedge clk);
        check("R11 all reads returned", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule